// File: doc/BRIEF.md
# Receive Descriptor Ring Sequencer

This block owns a small ring of receive descriptors and decides, frame by frame, whether an incoming frame may be stored and where. When a frame begins, it looks at the descriptor under its queue pointer. If software still holds that descriptor, the frame is refused. Otherwise the block follows the frame to its end. A good frame leads to a storage request. When the write-done handshake arrives, the descriptor is stamped with the frame length and the address-match reason, and it is handed to software. A receive-complete flag follows one cycle later.

Three failures are kept apart. A refused frame raises buffer-not-available. A frame whose data path overflows raises overrun. A frame that ends bad is counted in a saturating discard counter. In all three cases no descriptor is touched and the queue pointer stays where it is. Software returns a descriptor by clearing its ownership bit through a small write port. The same port sets the wrap bit that closes the ring early. A combinational read port shows any entry. Interrupt flags are sticky and are cleared by writing ones.

Top module: `rx_desc_ring`

## Requirements
- R1: After reset the queue pointer, `irq_flags`, `drop_cnt` and `store_req` are 0. Every entry has ownership bit 0, and only the last entry has its wrap bit set.
- R2: For a good frame (`frm_end` with `frm_good`=1), `store_req` is high from the cycle after `frm_end` until `wr_done` is sampled. At that edge the entry under the queue pointer gets ownership 1, the `frm_why` and `frm_len` values latched at `frm_end`, and an unchanged wrap bit.
- R3: The receive-complete flag `irq_flags[0]` rises one cycle after the descriptor update, that is, at the second edge after `wr_done` is sampled. It is still 0 after the first.
- R4: On each descriptor update the queue pointer moves to entry 0 if the updated entry has its wrap bit set. Otherwise it moves to the next entry.
- R5: If the entry under the queue pointer has ownership 1 when `frm_start` is sampled, the flag `irq_flags[2]` is set at that edge. The frame is ignored: no `store_req`, no descriptor change, no pointer move and no count.
- R6: If `fifo_ovr` is sampled while a frame is being received, `irq_flags[1]` is set. The rest of the frame is ignored: no `store_req`, no descriptor change, no pointer move and no count.
- R7: A frame that ends with `frm_good`=0 increments `drop_cnt` by one. It changes no descriptor, does not move the pointer and sets no flag.
- R8: `drop_cnt` saturates at its all-ones value.
- R9: Each flag stays set until a one is written to the matching bit of `irq_clr` (bit 0 complete, bit 1 overrun, bit 2 no buffer). Clearing one bit leaves the other bits unchanged.
- R10: When `sw_we` is high, the entry `sw_idx` takes the ownership bit `sw_own` and the wrap bit `sw_wrap` at the next edge. `rd_own`, `rd_wrap`, `rd_why` and `rd_len` show entry `sw_idx` combinationally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| frm_start | input | 1 | Pulse: a frame begins |
| frm_end | input | 1 | Pulse: the frame ends |
| frm_good | input | 1 | Frame status, valid with frm_end |
| fifo_ovr | input | 1 | Data path overflow during reception |
| frm_why | input | WHY_W | Address-match reason, valid with frm_end |
| frm_len | input | LEN_W | Frame length, valid with frm_end |
| wr_done | input | 1 | Payload storage finished |
| store_req | output | 1 | Payload storage requested |
| sw_we | input | 1 | Software descriptor write enable |
| sw_idx | input | IDX_W | Entry for software write and read |
| sw_own | input | 1 | Ownership bit to write |
| sw_wrap | input | 1 | Wrap bit to write |
| rd_own | output | 1 | Ownership bit of entry sw_idx |
| rd_wrap | output | 1 | Wrap bit of entry sw_idx |
| rd_why | output | WHY_W | Match reason of entry sw_idx |
| rd_len | output | LEN_W | Length of entry sw_idx |
| irq_clr | input | 3 | Write-one-to-clear for the flags |
| irq_flags | output | 3 | {no buffer, overrun, complete} |
| drop_cnt | output | CNT_W | Saturating count of bad frames |
| qptr | output | IDX_W | Queue pointer |

## Verification
Four result latencies matter. The descriptor, the queue pointer and `drop_cnt` settle one edge after the qualifying input: `wr_done`, `frm_end` or `frm_start`. `store_req` rises one edge after a good `frm_end`. The overrun and no-buffer flags appear one edge after their event. The complete flag arrives at the second edge after `wr_done`. The bench drives inputs and samples outputs on falling edges, so each check falls a whole number of edges after its stimulus. The R3 check samples at both edges after `wr_done` to confirm the one-cycle gap.

// File: rtl/rxd_pkg.sv
package rxd_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RECV,
    ST_SKIP,
    ST_STORE,
    ST_DONE
  } rxd_state_e;

  localparam int FLG_DONE  = 0;
  localparam int FLG_OVR   = 1;
  localparam int FLG_NOBUF = 2;
  localparam int FLG_N     = 3;
endpackage

// File: rtl/rxd_table.sv
module rxd_table #(
  parameter int DEPTH = 8,
  parameter int IDX_W = 3,
  parameter int LEN_W = 11,
  parameter int WHY_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             hw_we,
  input  logic [IDX_W-1:0] hw_idx,
  input  logic [WHY_W-1:0] hw_why,
  input  logic [LEN_W-1:0] hw_len,
  input  logic             sw_we,
  input  logic [IDX_W-1:0] sw_idx,
  input  logic             sw_own,
  input  logic             sw_wrap,
  input  logic [IDX_W-1:0] q_idx,
  output logic             q_own,
  output logic             q_wrap,
  output logic             r_own,
  output logic             r_wrap,
  output logic [WHY_W-1:0] r_why,
  output logic [LEN_W-1:0] r_len
);
  logic [DEPTH-1:0] own_q;
  logic [DEPTH-1:0] wrap_q;
  logic [WHY_W-1:0] why_q [DEPTH];
  logic [LEN_W-1:0] len_q [DEPTH];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int e = 0; e < DEPTH; e++) begin
        own_q[e]  <= 1'b0;
        wrap_q[e] <= (e == DEPTH - 1);
        why_q[e]  <= '0;
        len_q[e]  <= '0;
      end
    end else begin
      for (int e = 0; e < DEPTH; e++) begin
        // software port first; a hardware update of the same entry wins on ownership
        if (sw_we && sw_idx == IDX_W'(e)) begin
          own_q[e]  <= sw_own;
          wrap_q[e] <= sw_wrap;
        end
        if (hw_we && hw_idx == IDX_W'(e)) begin
          own_q[e] <= 1'b1;
          why_q[e] <= hw_why;
          len_q[e] <= hw_len;
        end
      end
    end
  end

  assign q_own  = own_q[q_idx];
  assign q_wrap = wrap_q[q_idx];
  assign r_own  = own_q[sw_idx];
  assign r_wrap = wrap_q[sw_idx];
  assign r_why  = why_q[sw_idx];
  assign r_len  = len_q[sw_idx];
endmodule

// File: rtl/rxd_seq.sv
module rxd_seq
  import rxd_pkg::*;
#(
  parameter int DEPTH = 8,
  parameter int IDX_W = 3,
  parameter int LEN_W = 11,
  parameter int WHY_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             frm_start,
  input  logic             frm_end,
  input  logic             frm_good,
  input  logic             fifo_ovr,
  input  logic [WHY_W-1:0] frm_why,
  input  logic [LEN_W-1:0] frm_len,
  input  logic             wr_done,
  input  logic             cur_own,
  input  logic             cur_wrap,
  output logic [IDX_W-1:0] qptr,
  output logic             store_req,
  output logic             desc_we,
  output logic [WHY_W-1:0] desc_why,
  output logic [LEN_W-1:0] desc_len,
  output logic             ev_done,
  output logic             ev_drop,
  output logic             ev_ovr,
  output logic             ev_nobuf
);
  function automatic logic [IDX_W-1:0] ring_next(input logic [IDX_W-1:0] p, input logic w);
    if (w || p == IDX_W'(DEPTH - 1)) return '0;
    return p + 1'b1;
  endfunction

  rxd_state_e st_q, st_d;
  logic [WHY_W-1:0] why_q;
  logic [LEN_W-1:0] len_q;
  logic             latch;

  always_comb begin
    st_d     = st_q;
    ev_nobuf = 1'b0;
    ev_ovr   = 1'b0;
    ev_drop  = 1'b0;
    ev_done  = 1'b0;
    desc_we  = 1'b0;
    latch    = 1'b0;
    unique case (st_q)
      ST_IDLE: if (frm_start) begin
        if (cur_own) begin
          ev_nobuf = 1'b1;
          st_d     = ST_SKIP;
        end else begin
          st_d = ST_RECV;
        end
      end
      ST_RECV: if (fifo_ovr) begin
        ev_ovr = 1'b1;
        st_d   = frm_end ? ST_IDLE : ST_SKIP;
      end else if (frm_end) begin
        if (frm_good) begin
          latch = 1'b1;
          st_d  = ST_STORE;
        end else begin
          ev_drop = 1'b1;
          st_d    = ST_IDLE;
        end
      end
      ST_SKIP: if (frm_end) st_d = ST_IDLE;
      ST_STORE: if (wr_done) begin
        desc_we = 1'b1;
        st_d    = ST_DONE;
      end
      ST_DONE: begin
        ev_done = 1'b1;
        st_d    = ST_IDLE;
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= ST_IDLE;
      qptr  <= '0;
      why_q <= '0;
      len_q <= '0;
    end else begin
      st_q <= st_d;
      if (latch) begin
        why_q <= frm_why;
        len_q <= frm_len;
      end
      if (desc_we) qptr <= ring_next(qptr, cur_wrap);
    end
  end

  assign store_req = (st_q == ST_STORE);
  assign desc_why  = why_q;
  assign desc_len  = len_q;
endmodule

// File: rtl/rxd_flags.sv
module rxd_flags
  import rxd_pkg::*;
#(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [FLG_N-1:0] ev_set,
  input  logic [FLG_N-1:0] clr,
  input  logic             ev_drop,
  output logic [FLG_N-1:0] flags,
  output logic [CNT_W-1:0] drop_cnt
);
  function automatic logic [CNT_W-1:0] sat_inc(input logic [CNT_W-1:0] v);
    return (&v) ? v : v + 1'b1;
  endfunction

  for (genvar b = 0; b < FLG_N; b++) begin : g_flag
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) flags[b] <= 1'b0;
      else        flags[b] <= ev_set[b] | (flags[b] & ~clr[b]);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       drop_cnt <= '0;
    else if (ev_drop) drop_cnt <= sat_inc(drop_cnt);
  end
endmodule

// File: rtl/rx_desc_ring.sv
module rx_desc_ring
  import rxd_pkg::*;
#(
  parameter int DEPTH = 8,
  parameter int IDX_W = $clog2(DEPTH),
  parameter int LEN_W = 11,
  parameter int WHY_W = 2,
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             frm_start,
  input  logic             frm_end,
  input  logic             frm_good,
  input  logic             fifo_ovr,
  input  logic [WHY_W-1:0] frm_why,
  input  logic [LEN_W-1:0] frm_len,
  input  logic             wr_done,
  output logic             store_req,
  input  logic             sw_we,
  input  logic [IDX_W-1:0] sw_idx,
  input  logic             sw_own,
  input  logic             sw_wrap,
  output logic             rd_own,
  output logic             rd_wrap,
  output logic [WHY_W-1:0] rd_why,
  output logic [LEN_W-1:0] rd_len,
  input  logic [2:0]       irq_clr,
  output logic [2:0]       irq_flags,
  output logic [CNT_W-1:0] drop_cnt,
  output logic [IDX_W-1:0] qptr
);
  logic             cur_own, cur_wrap, desc_we;
  logic [WHY_W-1:0] desc_why;
  logic [LEN_W-1:0] desc_len;
  logic             ev_done, ev_drop, ev_ovr, ev_nobuf;
  logic [FLG_N-1:0] ev_set;

  rxd_table #(.DEPTH(DEPTH), .IDX_W(IDX_W), .LEN_W(LEN_W), .WHY_W(WHY_W)) u_table (
    .clk(clk), .rst_n(rst_n),
    .hw_we(desc_we), .hw_idx(qptr), .hw_why(desc_why), .hw_len(desc_len),
    .sw_we(sw_we), .sw_idx(sw_idx), .sw_own(sw_own), .sw_wrap(sw_wrap),
    .q_idx(qptr), .q_own(cur_own), .q_wrap(cur_wrap),
    .r_own(rd_own), .r_wrap(rd_wrap), .r_why(rd_why), .r_len(rd_len)
  );

  rxd_seq #(.DEPTH(DEPTH), .IDX_W(IDX_W), .LEN_W(LEN_W), .WHY_W(WHY_W)) u_seq (
    .clk(clk), .rst_n(rst_n),
    .frm_start(frm_start), .frm_end(frm_end), .frm_good(frm_good),
    .fifo_ovr(fifo_ovr), .frm_why(frm_why), .frm_len(frm_len),
    .wr_done(wr_done), .cur_own(cur_own), .cur_wrap(cur_wrap),
    .qptr(qptr), .store_req(store_req), .desc_we(desc_we),
    .desc_why(desc_why), .desc_len(desc_len),
    .ev_done(ev_done), .ev_drop(ev_drop), .ev_ovr(ev_ovr), .ev_nobuf(ev_nobuf)
  );

  always_comb begin
    ev_set            = '0;
    ev_set[FLG_DONE]  = ev_done;
    ev_set[FLG_OVR]   = ev_ovr;
    ev_set[FLG_NOBUF] = ev_nobuf;
  end

  rxd_flags #(.CNT_W(CNT_W)) u_flags (
    .clk(clk), .rst_n(rst_n),
    .ev_set(ev_set), .clr(irq_clr), .ev_drop(ev_drop),
    .flags(irq_flags), .drop_cnt(drop_cnt)
  );
endmodule

// File: rtl/rxd_chk.sv
module rxd_chk #(
  parameter int IDX_W = 3,
  parameter int CNT_W = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic [IDX_W-1:0] qptr,
  input logic             cur_wrap,
  input logic             desc_we,
  input logic             ev_done,
  input logic             ev_drop,
  input logic             ev_ovr,
  input logic             ev_nobuf,
  input logic             store_req,
  input logic [2:0]       irq_flags,
  input logic [2:0]       irq_clr,
  input logic [CNT_W-1:0] drop_cnt
);
  localparam logic [CNT_W-1:0] CMAX = '1;

  p_done_after_write_r3: assert property (@(posedge clk) disable iff (!rst_n)
    desc_we |=> ev_done);
  p_done_flag_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ev_done |=> irq_flags[0]);
  p_ring_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
    desc_we |=> qptr == ($past(cur_wrap) ? '0 : IDX_W'($past(qptr) + 1'b1)));
  p_ptr_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !desc_we |=> $stable(qptr));
  p_nobuf_refuse_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ev_nobuf |=> (!store_req && irq_flags[2]));
  p_ovr_flag_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ev_ovr |=> (irq_flags[1] && !store_req));
  p_drop_step_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_drop && drop_cnt != CMAX) |=> drop_cnt == $past(drop_cnt) + 1'b1);
  p_drop_sat_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (drop_cnt == CMAX) |=> drop_cnt == CMAX);
  p_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_flags[1] && !irq_clr[1]) |=> irq_flags[1]);
endmodule

bind rx_desc_ring rxd_chk #(.IDX_W(IDX_W), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .qptr(qptr), .cur_wrap(cur_wrap),
  .desc_we(desc_we), .ev_done(ev_done), .ev_drop(ev_drop), .ev_ovr(ev_ovr),
  .ev_nobuf(ev_nobuf), .store_req(store_req), .irq_flags(irq_flags),
  .irq_clr(irq_clr), .drop_cnt(drop_cnt)
);

// File: tb/sim_rx_desc_ring.sv
`timescale 1ns/1ps
module sim_rx_desc_ring;
  localparam int DEPTH = 8;
  localparam int IDX_W = 3;
  localparam int LEN_W = 11;
  localparam int WHY_W = 2;
  localparam int CNT_W = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic frm_start = 0, frm_end = 0, frm_good = 0, fifo_ovr = 0, wr_done = 0;
  logic [WHY_W-1:0] frm_why = '0;
  logic [LEN_W-1:0] frm_len = '0;
  logic store_req;
  logic sw_we = 0, sw_own = 0, sw_wrap = 0;
  logic [IDX_W-1:0] sw_idx = '0;
  logic rd_own, rd_wrap;
  logic [WHY_W-1:0] rd_why;
  logic [LEN_W-1:0] rd_len;
  logic [2:0] irq_clr = '0;
  logic [2:0] irq_flags;
  logic [CNT_W-1:0] drop_cnt;
  logic [IDX_W-1:0] qptr;

  int n_run = 0;
  int n_fail = 0;

  always #5 clk = ~clk;

  rx_desc_ring u0 (
    .clk(clk), .rst_n(rst_n), .frm_start(frm_start), .frm_end(frm_end),
    .frm_good(frm_good), .fifo_ovr(fifo_ovr), .frm_why(frm_why), .frm_len(frm_len),
    .wr_done(wr_done), .store_req(store_req), .sw_we(sw_we), .sw_idx(sw_idx),
    .sw_own(sw_own), .sw_wrap(sw_wrap), .rd_own(rd_own), .rd_wrap(rd_wrap),
    .rd_why(rd_why), .rd_len(rd_len), .irq_clr(irq_clr), .irq_flags(irq_flags),
    .drop_cnt(drop_cnt), .qptr(qptr)
  );

  // kinds: 0 good, 1 bad, 2 overrun
  localparam int NV = 8;
  localparam int V_KIND [NV] = '{0, 1, 2, 0, 0, 1, 0, 0};
  localparam int V_WHY  [NV] = '{1, 0, 0, 2, 3, 0, 0, 1};
  localparam int V_LEN  [NV] = '{64, 70, 80, 100, 200, 90, 1500, 9};
  localparam int V_Q    [NV] = '{1, 1, 1, 2, 3, 3, 4, 5};
  localparam int V_CNT  [NV] = '{0, 1, 1, 1, 1, 2, 2, 2};
  localparam int V_FLG  [NV] = '{1, 0, 2, 1, 1, 0, 1, 1};

  task automatic chk(input string req, input int act, input int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic frame(input int kind, input int why, input int len);
    @(negedge clk) frm_start = 1;
    @(negedge clk) frm_start = 0;
    if (kind == 2) begin
      fifo_ovr = 1;
      @(negedge clk) fifo_ovr = 0;
    end
    frm_end = 1; frm_good = (kind == 0); frm_why = WHY_W'(why); frm_len = LEN_W'(len);
    @(negedge clk) frm_end = 0; frm_good = 0;
    if (kind == 0) begin
      wr_done = 1;
      @(negedge clk) wr_done = 0;
    end
    @(negedge clk);
  endtask

  task automatic clear_flags(input logic [2:0] m);
    irq_clr = m;
    @(negedge clk) irq_clr = '0;
  endtask

  task automatic sw_write(input int idx, input logic own, input logic wrap);
    sw_idx = IDX_W'(idx); sw_own = own; sw_wrap = wrap; sw_we = 1;
    @(negedge clk) sw_we = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    chk("R1 qptr", qptr, 0);
    chk("R1 flags", irq_flags, 0);
    chk("R1 cnt", drop_cnt, 0);
    chk("R1 store_req", store_req, 0);
    for (int i = 0; i < DEPTH; i++) begin
      sw_idx = IDX_W'(i);
      #1;
      chk("R1 own", rd_own, 0);
      chk("R1 wrap", rd_wrap, (i == DEPTH - 1) ? 1 : 0);
    end

    // vector table: R2 R6 R7 over mixed frames
    for (int v = 0; v < NV; v++) begin
      frame(V_KIND[v], V_WHY[v], V_LEN[v]);
      chk("R2/R6/R7 qptr", qptr, V_Q[v]);
      chk("R7 cnt", drop_cnt, V_CNT[v]);
      chk("R3/R6 flags", irq_flags, V_FLG[v]);
      clear_flags(3'b111);
    end
    sw_idx = 0; #1;
    chk("R2 entry0 own", rd_own, 1);
    chk("R2 entry0 why", rd_why, 1);
    chk("R2 entry0 len", rd_len, 64);
    sw_idx = 1; #1;
    chk("R6 entry1 untouched len", rd_len, 100);

    // R2 and R3 cycle by cycle, entry 5
    @(negedge clk) frm_start = 1;
    @(negedge clk) frm_start = 0;
    frm_end = 1; frm_good = 1; frm_why = 2; frm_len = 300;
    chk("R2 no req before end", store_req, 0);
    @(negedge clk) frm_end = 0; frm_good = 0;
    chk("R2 req after end", store_req, 1);
    @(negedge clk);
    chk("R2 req held", store_req, 1);
    wr_done = 1;
    @(negedge clk) wr_done = 0;
    sw_idx = 5; #1;
    chk("R2 own set", rd_own, 1);
    chk("R2 why", rd_why, 2);
    chk("R2 len", rd_len, 300);
    chk("R4 qptr step", qptr, 6);
    chk("R3 flag not yet", irq_flags[0], 0);
    chk("R2 req dropped", store_req, 0);
    @(negedge clk);
    chk("R3 flag one cycle later", irq_flags[0], 1);
    clear_flags(3'b001);

    // R4 wrap at last entry
    frame(0, 1, 10);
    frame(0, 1, 11);
    chk("R4 wrap to zero", qptr, 0);
    clear_flags(3'b111);

    // R5 owned entry
    @(negedge clk) frm_start = 1;
    @(negedge clk) frm_start = 0;
    chk("R5 nobuf flag", irq_flags, 4);
    frm_end = 1; frm_good = 1; frm_len = 999;
    @(negedge clk) frm_end = 0; frm_good = 0;
    chk("R5 no req", store_req, 0);
    @(negedge clk);
    chk("R5 qptr hold", qptr, 0);
    chk("R5 cnt hold", drop_cnt, 2);
    sw_idx = 0; #1;
    chk("R5 entry0 len kept", rd_len, 64);

    // R10 release entry 0
    sw_write(0, 0, 0);
    sw_idx = 0; #1;
    chk("R10 own cleared", rd_own, 0);

    // R9 sticky and per-bit clear
    frame(1, 0, 5);
    chk("R7 cnt", drop_cnt, 3);
    chk("R9 sticky nobuf", irq_flags, 4);
    clear_flags(3'b010);
    chk("R9 other bit kept", irq_flags, 4);
    clear_flags(3'b100);
    chk("R9 cleared", irq_flags, 0);

    // R4 R10 early wrap at entry 1
    sw_write(1, 0, 1);
    sw_idx = 1; #1;
    chk("R10 wrap set", rd_wrap, 1);
    frame(0, 3, 20);
    chk("R4 step", qptr, 1);
    frame(0, 3, 21);
    chk("R4 early wrap", qptr, 0);
    clear_flags(3'b111);

    // R6 overrun leaves entry 0 free
    sw_write(0, 0, 0);
    frame(2, 0, 0);
    chk("R6 ovr flag", irq_flags, 2);
    chk("R6 qptr hold", qptr, 0);
    sw_idx = 0; #1;
    chk("R6 entry0 free", rd_own, 0);
    chk("R6 entry0 len kept", rd_len, 20);
    clear_flags(3'b111);

    // R8 saturation
    for (int k = 0; k < 14; k++) frame(1, 0, 1);
    chk("R8 saturated", drop_cnt, 15);
    chk("R7 no flags", irq_flags, 0);

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule